// File: doc/BRIEF.md
# Integrate-and-Fire Pulse Neuron

This block is a digital neuron that turns two streams of charge increments into a pulse-rate output. One input bus brings charge from positive-weight synapses and the other brings charge from negative-weight synapses. Each bus has its own valid strobe. Every cycle the neuron adds the net difference into an accumulator. The accumulator cannot fall below zero and saturates at its top value. When the accumulator reaches a threshold that software can program, the neuron emits one output pulse of fixed width. In the same cycle it clears the accumulator completely. It does not subtract the threshold.

A minimum quiet interval follows each pulse, so the output rate can never exceed one pulse per `1 + PULSE_W + MIN_GAP` cycles. Integration keeps running during the pulse and during the quiet interval. A stronger net input therefore gives a shorter period, until that ceiling is reached. A net input of zero or less gives no pulses.

The control is a three-state machine:
- `ST_INTEG` integrates and checks the threshold. It takes the transition *fire* to `ST_FIRE` when the accumulator is at or above the threshold.
- `ST_FIRE` drives the output high. It takes the transition *width done* to `ST_GAP` after `PULSE_W` cycles.
- `ST_GAP` holds the output low. It takes the transition *gap done* back to `ST_INTEG` after `MIN_GAP` cycles.

Top module: `pulse_neuron`

## Requirements
- R1: Each cycle the accumulator changes by `pos_inc` (only when `pos_vld` is high) minus `neg_inc` (only when `neg_vld` is high). With both strobes low, an increment on either bus has no effect.
- R2: The accumulator never goes below 0, so a negative net input leaves it at 0. It saturates at 2^ACC_W-1 and does not wrap.
- R3: In `ST_INTEG`, an accumulator value greater than or equal to the threshold causes a firing. `spike` goes high in the next cycle.
- R4: A firing clears the accumulator to 0, and the increments presented in the firing cycle are discarded.
- R5: `spike` stays high for exactly `PULSE_W` consecutive cycles per pulse.
- R6: Between two pulses `spike` is low for at least `MIN_GAP`+1 cycles. Integration continues during the pulse and the gap. Under a constant net increment d > 0 and threshold T, the rising-edge period is `PULSE_W+MIN_GAP+1+max(0, ceil((T-(PULSE_W+MIN_GAP)*d)/d))` cycles.
- R7: The threshold register loads `thr_wdata` on a cycle with `thr_we` high and takes effect from the next cycle. Reset loads `THR_RST` (default 100).
- R8: The output pulse period does not increase as the net input grows. A net input of zero or less produces no pulses once the accumulator is 0.
- R9: Reset gives `spike` low, the accumulator at 0 and the state `ST_INTEG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | ACC_W | New threshold value |
| pos_vld | input | 1 | Positive increment valid |
| pos_inc | input | INC_W | Positive-weight charge increment |
| neg_vld | input | 1 | Negative increment valid |
| neg_inc | input | INC_W | Negative-weight charge increment |
| spike | output | 1 | Output pulse line |

## Verification
The bench goes after these corner cases:
- **Zero threshold.** The neuron should fire back to back at the rate ceiling. A design that compared with a strict greater-than would stay silent.
- **Same-cycle increments.** A second pulse is set up by increments that arrive in the firing cycle. A design that kept them would emit that second pulse.
- **Long negative input.** Strong negative input is applied before positive input. A design without the floor at zero would be late to fire.
- **Threshold at the top of range.** A design that wrapped instead of saturating would fire far too slowly.
- **Masked increments.** A large increment with its strobe low must have no effect. If the strobe were ignored, pulses would appear.

Measured periods across increasing input strengths must not get longer.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
    typedef enum logic [1:0] {
        ST_INTEG = 2'd0,
        ST_FIRE  = 2'd1,
        ST_GAP   = 2'd2
    } nstate_t;
endpackage

// File: rtl/neuron_integrator.sv
module neuron_integrator #(
    parameter int ACC_W = 12,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pos_vld,
    input  logic [INC_W-1:0] pos_inc,
    input  logic             neg_vld,
    input  logic [INC_W-1:0] neg_inc,
    output logic [ACC_W-1:0] acc_q
);
    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] ACC_MAX = $signed({2'b00, {ACC_W{1'b1}}});

    logic signed [SUM_W-1:0] pos_ext;
    logic signed [SUM_W-1:0] neg_ext;
    logic signed [SUM_W-1:0] sum;
    logic [ACC_W-1:0]        acc_d;

    always_comb begin
        pos_ext = pos_vld ? $signed({{(SUM_W-INC_W){1'b0}}, pos_inc}) : '0;
        neg_ext = neg_vld ? $signed({{(SUM_W-INC_W){1'b0}}, neg_inc}) : '0;
        sum     = $signed({2'b00, acc_q}) + pos_ext - neg_ext;
        if (sum < 0)
            acc_d = '0;
        else if (sum > ACC_MAX)
            acc_d = {ACC_W{1'b1}};
        else
            acc_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/neuron_timer.sv
module neuron_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pulse_neuron.sv
module pulse_neuron
    import neuron_pkg::*;
#(
    parameter int ACC_W   = 12,
    parameter int INC_W   = 8,
    parameter int PULSE_W = 4,
    parameter int MIN_GAP = 3,
    parameter int THR_RST = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [ACC_W-1:0] thr_wdata,
    input  logic             pos_vld,
    input  logic [INC_W-1:0] pos_inc,
    input  logic             neg_vld,
    input  logic [INC_W-1:0] neg_inc,
    output logic             spike
);
    localparam int SPAN  = (PULSE_W > MIN_GAP) ? PULSE_W : MIN_GAP;
    localparam int CNT_W = $clog2(SPAN + 1);

    nstate_t          state_q, state_d;
    logic [ACC_W-1:0] thr_q;
    logic [ACC_W-1:0] acc;
    logic             fire;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= ACC_W'(THR_RST);
        else if (thr_we)
            thr_q <= thr_wdata;
    end

    neuron_integrator #(.ACC_W(ACC_W), .INC_W(INC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fire),
        .pos_vld (pos_vld),
        .pos_inc (pos_inc),
        .neg_vld (neg_vld),
        .neg_inc (neg_inc),
        .acc_q   (acc)
    );

    neuron_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_INTEG;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_INTEG: begin
                if (acc >= thr_q) begin
                    fire     = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_W - 1);
                    state_d  = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(MIN_GAP - 1);
                    state_d  = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_done)
                    state_d = ST_INTEG;
            end
            default: state_d = ST_INTEG;
        endcase
    end

    always_comb begin
        spike = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/neuron_chk.sv
module neuron_chk #(
    parameter int ACC_W   = 12,
    parameter int PULSE_W = 4,
    parameter int MIN_GAP = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spike,
    input logic             in_integ,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] thr,
    input logic             pos_vld,
    input logic             neg_vld
);
    logic [7:0] hi_cnt;
    logic [7:0] lo_cnt;
    logic       fire_seen;

    assign fire_seen = in_integ && (acc >= thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= 8'hFF;
        end else if (spike) begin
            hi_cnt <= hi_cnt + 1'b1;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != 8'hFF)
                lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R4
    fire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_seen |=> (acc == '0));

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spike) |-> $past(fire_seen));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spike) |-> (hi_cnt == 8'(PULSE_W)));

    // R6
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spike) |-> (lo_cnt >= 8'(MIN_GAP + 1)));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_integ && !pos_vld && !neg_vld && (acc < thr)) |=> $stable(acc));
endmodule

bind pulse_neuron neuron_chk #(
    .ACC_W   (ACC_W),
    .PULSE_W (PULSE_W),
    .MIN_GAP (MIN_GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spike    (spike),
    .in_integ (state_q == neuron_pkg::ST_INTEG),
    .acc      (acc),
    .thr      (thr_q),
    .pos_vld  (pos_vld),
    .neg_vld  (neg_vld)
);

// File: tb/sim_pulse_neuron.sv
module sim_pulse_neuron;
    localparam int ACC_W = 12;
    localparam int INC_W = 8;
    localparam int NROWS = 10;
    // thr, pos_inc, neg_inc, expected period (0 = silent)
    localparam int VEC [NROWS][4] = '{
        '{100,  10,   0, 11},
        '{100,  30,   5,  8},
        '{100,   5,   0, 21},
        '{100,   2,   5,  0},
        '{100,   7,   7,  0},
        '{200,  20,   0, 11},
        '{ 50,   1,   0, 51},
        '{  0,   0,   0,  8},
        '{255,  60,  10,  8},
        '{4095, 255,  0, 18}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             thr_we = 1'b0;
    logic [ACC_W-1:0] thr_wdata = '0;
    logic             pos_vld = 1'b0;
    logic [INC_W-1:0] pos_inc = '0;
    logic             neg_vld = 1'b0;
    logic [INC_W-1:0] neg_inc = '0;
    logic             spike;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int per [NROWS];

    always #4 clk = ~clk;

    pulse_neuron u0 (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .pos_vld(pos_vld), .pos_inc(pos_inc), .neg_vld(neg_vld),
        .neg_inc(neg_inc), .spike(spike)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pos_vld = 1'b0; neg_vld = 1'b0; thr_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rise(input int lim, output int n);
        logic prev;
        prev = spike;
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (spike && !prev) begin
                n = i;
                break;
            end
            prev = spike;
        end
    endtask

    initial begin
        int n1, n2, w, rises;
        logic prev;

        do_reset();
        // R9: output low out of reset
        check("R9", int'(spike), 0);

        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            thr_we = 1'b1; thr_wdata = ACC_W'(VEC[r][0]);
            @(negedge clk);
            thr_we = 1'b0;
            pos_vld = 1'b1; pos_inc = INC_W'(VEC[r][1]);
            neg_vld = 1'b1; neg_inc = INC_W'(VEC[r][2]);
            wait_rise(1000, n1);
            if (VEC[r][3] == 0) begin
                // R8: no pulses for zero or negative net input
                check("R8", n1, -1);
                per[r] = 0;
            end else begin
                wait_rise(200, n2);
                per[r] = n2;
                // R6 / R7 / R2 (row 9: saturation) steady period
                check("R6", n2, VEC[r][3]);
                if (r == 0) begin
                    w = 1;
                    while (spike && w < 50) begin
                        @(negedge clk);
                        if (spike) w++;
                    end
                    // R5: pulse width
                    check("R5", w, 4);
                end
            end
        end
        // R8: monotonic, rows with d=5,10,25 at thr 100
        check("R8", int'((per[2] >= per[0]) && (per[0] >= per[1])), 1);

        // R2 floor and R7 reset threshold
        do_reset();
        neg_vld = 1'b1; neg_inc = 8'd100;
        repeat (20) @(negedge clk);
        neg_vld = 1'b0; pos_vld = 1'b1; pos_inc = 8'd10;
        wait_rise(100, n1);
        check("R2", n1, 11);

        // R1: masked increments ignored
        do_reset();
        pos_vld = 1'b0; pos_inc = 8'd200; neg_vld = 1'b0;
        wait_rise(100, n1);
        check("R1", n1, -1);

        // R4: increments in firing cycle discarded
        do_reset();
        rises = 0;
        prev = spike;
        for (int i = 0; i < 60; i++) begin
            if (spike && !prev) rises++;
            prev = spike;
            pos_vld = (i < 3);
            pos_inc = (i == 0) ? 8'd100 : (i == 1) ? 8'd60 : 8'd40;
            @(negedge clk);
        end
        check("R4", rises, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule